// File: doc/BRIEF.md
# Address and Stack Fault Detector

This block watches three streams of processor activity: data accesses, instruction fetches together with literal jump or branch targets, and writes to the stack pointer. Every cycle it checks the active streams against fixed memory-map bounds and against a software-loaded stack ceiling. A failing check raises a one-cycle pulse on one of two outputs, one for address faults and one for stack faults. The trap logic downstream turns these pulses into exceptions.

A three-bit sticky cause register records which check fired, so a handler can tell the failing conditions apart. It keeps its code until software pulses the clear strobe. The bounds of implemented data space, implemented program space, the vector table and the stack floor are parameters. The stack ceiling is a register loaded through its own write strobe.

Top module: `addr_fault_det`

## Requirements
- R1: A word access (`dacc_word`=1) on the data port to an odd byte address raises `addr_err` on the cycle after the access is sampled. A byte access to an odd address raises nothing. Cause code 1.
- R2: A data-space access (`dacc_prog`=0) below `DMEM_LO` (default 0x0800) or above `DMEM_HI` (default 0x0FFF) raises `addr_err` one cycle later. Cause code 2.
- R3: A program-space access (`dacc_prog`=1) above `PMEM_HI` (default 0x007FFF) raises `addr_err` one cycle later. Cause code 3.
- R4: An instruction fetch whose address lies in the vector table, 0x000000 to `VEC_HI` (default 0x0000FE) inclusive, raises `addr_err` one cycle later. Cause code 4.
- R5: An instruction fetch, or a jump/branch literal target, above `PMEM_HI` raises `addr_err` one cycle later. Cause code 5.
- R6: A stack pointer write whose value is strictly above the ceiling register raises `stack_err` one cycle later (cause code 6). The ceiling resets to all ones. A ceiling write takes effect from the following cycle, so an SP write in the same cycle is compared with the old ceiling.
- R7: A stack pointer write below `SP_FLOOR` (default 0x0800) raises `stack_err` one cycle later. Cause code 7.
- R8: Each check is evaluated only while its own valid or write strobe is high. The fault outputs are single-cycle pulses that drop when no failing access follows.
- R9: `addr_err` and `stack_err` may pulse in the same cycle. When several checks fail at once, the cause recorded is the first present in the order 6, 7, 1, 2, 3, 4, 5.
- R10: A nonzero cause holds until `cause_clr` is pulsed. A clear with no fault in the same cycle gives 0. A clear in the same cycle as a fault loads that fault's code.
- R11: During and after reset, `addr_err`, `stack_err` and `cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dacc_valid | input | 1 | Data port access valid |
| dacc_prog | input | 1 | 1: access targets program space, 0: data space |
| dacc_word | input | 1 | 1: word access, 0: byte access |
| dacc_addr | input | AW | Byte address of the access |
| fetch_valid | input | 1 | Instruction fetch valid |
| fetch_addr | input | AW | Fetch address |
| br_valid | input | 1 | Literal jump/branch issued |
| br_target | input | AW | Literal jump/branch target |
| sp_wr | input | 1 | Stack pointer write strobe |
| sp_wdata | input | SPW | Value written to the stack pointer |
| lim_wr | input | 1 | Stack ceiling write strobe |
| lim_wdata | input | SPW | New stack ceiling value |
| cause_clr | input | 1 | Clears the sticky cause |
| addr_err | output | 1 | Address fault pulse |
| stack_err | output | 1 | Stack fault pulse |
| cause | output | 3 | Sticky cause code |

## Verification
The bound checker watches, on every cycle, the checks that depend only on the current inputs: odd word accesses, vector-space fetches, stack writes under the floor, silence while no strobe is active, and the stickiness of a nonzero cause. The overflow check depends on ceiling state written earlier, and some outcomes depend on what else fails in the same cycle. Those cases are covered only by the bench scenarios. They are the reset ceiling, the old-ceiling comparison when a write and a ceiling load share a cycle, the equal-to-ceiling boundary, priority among simultaneous faults, and a clear arriving together with a fault.

// File: rtl/afd_pkg.sv
package afd_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE         = 3'd0,
        CAUSE_MISALIGN     = 3'd1,
        CAUSE_DATA_UNIMPL  = 3'd2,
        CAUSE_PROG_UNIMPL  = 3'd3,
        CAUSE_VEC_FETCH    = 3'd4,
        CAUSE_FETCH_UNIMPL = 3'd5,
        CAUSE_STK_OVF      = 3'd6,
        CAUSE_STK_UNF      = 3'd7
    } afd_cause_e;

    typedef struct packed {
        logic misalign;
        logic data_unimpl;
        logic prog_unimpl;
        logic vec_fetch;
        logic fetch_unimpl;
    } afd_addr_hits_t;

    typedef struct packed {
        logic ovf;
        logic unf;
    } afd_stk_hits_t;

    typedef struct packed {
        logic       addr_err;
        logic       stack_err;
        afd_cause_e cause;
    } afd_state_t;

    // Stack faults outrank address faults; overflow outranks underflow.
    function automatic afd_cause_e afd_pick_cause(afd_addr_hits_t a, afd_stk_hits_t s);
        afd_cause_e c;
        c = CAUSE_NONE;
        if (s.ovf)               c = CAUSE_STK_OVF;
        else if (s.unf)          c = CAUSE_STK_UNF;
        else if (a.misalign)     c = CAUSE_MISALIGN;
        else if (a.data_unimpl)  c = CAUSE_DATA_UNIMPL;
        else if (a.prog_unimpl)  c = CAUSE_PROG_UNIMPL;
        else if (a.vec_fetch)    c = CAUSE_VEC_FETCH;
        else if (a.fetch_unimpl) c = CAUSE_FETCH_UNIMPL;
        return c;
    endfunction

endpackage

// File: rtl/afd_data_chk.sv
module afd_data_chk #(
    parameter int unsigned AW      = 24,
    parameter int unsigned DMEM_LO = 'h0800,
    parameter int unsigned DMEM_HI = 'h0FFF,
    parameter int unsigned PMEM_HI = 'h7FFF
) (
    input  logic          valid,
    input  logic          prog,
    input  logic          word,
    input  logic [AW-1:0] addr,
    output logic          misalign,
    output logic          data_unimpl,
    output logic          prog_unimpl
);
    localparam logic [AW-1:0] D_LO = AW'(DMEM_LO);
    localparam logic [AW-1:0] D_HI = AW'(DMEM_HI);
    localparam logic [AW-1:0] P_HI = AW'(PMEM_HI);

    logic below_d, above_d, above_p;

    always_comb begin
        below_d     = addr < D_LO;
        above_d     = addr > D_HI;
        above_p     = addr > P_HI;
        misalign    = valid && word && addr[0];
        data_unimpl = valid && !prog && (below_d || above_d);
        prog_unimpl = valid && prog && above_p;
    end
endmodule

// File: rtl/afd_fetch_chk.sv
module afd_fetch_chk #(
    parameter int unsigned AW      = 24,
    parameter int unsigned VEC_HI  = 'h00FE,
    parameter int unsigned PMEM_HI = 'h7FFF
) (
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          br_valid,
    input  logic [AW-1:0] br_target,
    output logic          vec_fetch,
    output logic          fetch_unimpl
);
    localparam int unsigned NSRC = 2;
    localparam logic [AW-1:0] V_HI = AW'(VEC_HI);
    localparam logic [AW-1:0] P_HI = AW'(PMEM_HI);

    logic [NSRC-1:0]         src_vld;
    logic [NSRC-1:0][AW-1:0] src_addr;
    logic [NSRC-1:0]         src_bad;

    always_comb begin
        src_vld[0]  = fetch_valid;
        src_addr[0] = fetch_addr;
        src_vld[1]  = br_valid;
        src_addr[1] = br_target;
    end

    // Each program-flow address source gets its own bound comparator.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb src_bad[i] = src_vld[i] && (src_addr[i] > P_HI);
    end

    always_comb begin
        vec_fetch    = fetch_valid && (fetch_addr <= V_HI);
        fetch_unimpl = |src_bad;
    end
endmodule

// File: rtl/afd_stack_chk.sv
module afd_stack_chk #(
    parameter int unsigned SPW      = 16,
    parameter int unsigned SP_FLOOR = 'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sp_wr,
    input  logic [SPW-1:0] sp_wdata,
    input  logic           lim_wr,
    input  logic [SPW-1:0] lim_wdata,
    output logic           ovf,
    output logic           unf
);
    localparam logic [SPW-1:0] FLOOR = SPW'(SP_FLOOR);

    logic [SPW-1:0] lim_d, lim_q;

    always_comb begin
        lim_d = lim_wr ? lim_wdata : lim_q;
        ovf   = sp_wr && (sp_wdata > lim_q);
        unf   = sp_wr && (sp_wdata < FLOOR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lim_q <= '1;
        else        lim_q <= lim_d;
    end
endmodule

// File: rtl/addr_fault_det.sv
module addr_fault_det
    import afd_pkg::*;
#(
    parameter int unsigned AW       = 24,
    parameter int unsigned SPW      = 16,
    parameter int unsigned DMEM_LO  = 'h0800,
    parameter int unsigned DMEM_HI  = 'h0FFF,
    parameter int unsigned PMEM_HI  = 'h7FFF,
    parameter int unsigned VEC_HI   = 'h00FE,
    parameter int unsigned SP_FLOOR = 'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dacc_valid,
    input  logic           dacc_prog,
    input  logic           dacc_word,
    input  logic [AW-1:0]  dacc_addr,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_addr,
    input  logic           br_valid,
    input  logic [AW-1:0]  br_target,
    input  logic           sp_wr,
    input  logic [SPW-1:0] sp_wdata,
    input  logic           lim_wr,
    input  logic [SPW-1:0] lim_wdata,
    input  logic           cause_clr,
    output logic           addr_err,
    output logic           stack_err,
    output logic [2:0]     cause
);
    afd_addr_hits_t ahit;
    afd_stk_hits_t  shit;
    afd_state_t     st_d, st_q;
    afd_cause_e     hit_cause;

    afd_data_chk #(
        .AW(AW), .DMEM_LO(DMEM_LO), .DMEM_HI(DMEM_HI), .PMEM_HI(PMEM_HI)
    ) u_data (
        .valid       (dacc_valid),
        .prog        (dacc_prog),
        .word        (dacc_word),
        .addr        (dacc_addr),
        .misalign    (ahit.misalign),
        .data_unimpl (ahit.data_unimpl),
        .prog_unimpl (ahit.prog_unimpl)
    );

    afd_fetch_chk #(
        .AW(AW), .VEC_HI(VEC_HI), .PMEM_HI(PMEM_HI)
    ) u_fetch (
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .br_valid     (br_valid),
        .br_target    (br_target),
        .vec_fetch    (ahit.vec_fetch),
        .fetch_unimpl (ahit.fetch_unimpl)
    );

    afd_stack_chk #(
        .SPW(SPW), .SP_FLOOR(SP_FLOOR)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .sp_wr     (sp_wr),
        .sp_wdata  (sp_wdata),
        .lim_wr    (lim_wr),
        .lim_wdata (lim_wdata),
        .ovf       (shit.ovf),
        .unf       (shit.unf)
    );

    always_comb begin
        hit_cause      = afd_pick_cause(ahit, shit);
        st_d           = st_q;
        st_d.addr_err  = |ahit;
        st_d.stack_err = |shit;
        if (cause_clr || st_q.cause == CAUSE_NONE) st_d.cause = hit_cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{addr_err: 1'b0, stack_err: 1'b0, cause: CAUSE_NONE};
        else        st_q <= st_d;
    end

    assign addr_err  = st_q.addr_err;
    assign stack_err = st_q.stack_err;
    assign cause     = st_q.cause;
endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
    parameter int unsigned AW       = 24,
    parameter int unsigned SPW      = 16,
    parameter int unsigned VEC_HI   = 'h00FE,
    parameter int unsigned SP_FLOOR = 'h0800
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dacc_valid,
    input logic           dacc_word,
    input logic [AW-1:0]  dacc_addr,
    input logic           fetch_valid,
    input logic [AW-1:0]  fetch_addr,
    input logic           br_valid,
    input logic           sp_wr,
    input logic [SPW-1:0] sp_wdata,
    input logic           cause_clr,
    input logic           addr_err,
    input logic           stack_err,
    input logic [2:0]     cause
);
    localparam logic [AW-1:0]  V_HI  = AW'(VEC_HI);
    localparam logic [SPW-1:0] FLOOR = SPW'(SP_FLOOR);

    assert_misalign_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc_valid && dacc_word && dacc_addr[0]) |=> addr_err);

    assert_vec_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_addr <= V_HI) |=> addr_err);

    assert_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr && sp_wdata < FLOOR) |=> stack_err);

    assert_quiet_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dacc_valid && !fetch_valid && !br_valid) |=> !addr_err);

    assert_quiet_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_wr |=> !stack_err);

    assert_cause_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_err || stack_err) |-> cause != 3'd0);

    assert_cause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_clr && cause != 3'd0) |=> $stable(cause));

    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |-> (!addr_err && !stack_err && cause == 3'd0));
endmodule

bind addr_fault_det afd_checker #(
    .AW(AW), .SPW(SPW), .VEC_HI(VEC_HI), .SP_FLOOR(SP_FLOOR)
) u_afd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .dacc_valid  (dacc_valid),
    .dacc_word   (dacc_word),
    .dacc_addr   (dacc_addr),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .br_valid    (br_valid),
    .sp_wr       (sp_wr),
    .sp_wdata    (sp_wdata),
    .cause_clr   (cause_clr),
    .addr_err    (addr_err),
    .stack_err   (stack_err),
    .cause       (cause)
);

// File: tb/addr_fault_det_bench.sv
`timescale 1ns/1ps
module addr_fault_det_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dacc_valid = 0, dacc_prog = 0, dacc_word = 0;
    logic [23:0] dacc_addr = '0;
    logic        fetch_valid = 0;
    logic [23:0] fetch_addr = '0;
    logic        br_valid = 0;
    logic [23:0] br_target = '0;
    logic        sp_wr = 0;
    logic [15:0] sp_wdata = '0;
    logic        lim_wr = 0;
    logic [15:0] lim_wdata = '0;
    logic        cause_clr = 0;
    logic        addr_err, stack_err;
    logic [2:0]  cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        string    tag;
        bit       ae;
        bit       se;
        bit [2:0] c;
    } exp_t;
    exp_t exq[$];

    always #5 clk = ~clk;

    addr_fault_det u_addr_fault_det (
        .clk(clk), .rst_n(rst_n),
        .dacc_valid(dacc_valid), .dacc_prog(dacc_prog), .dacc_word(dacc_word),
        .dacc_addr(dacc_addr), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .br_valid(br_valid), .br_target(br_target), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata), .cause_clr(cause_clr),
        .addr_err(addr_err), .stack_err(stack_err), .cause(cause)
    );

    task automatic compare(string tag, bit ae, bit se, bit [2:0] c);
        n_chk++;
        if (addr_err !== ae || stack_err !== se || cause !== c) begin
            n_fail++;
            $display("FAIL %s: got ae=%b se=%b cause=%0d, expected ae=%b se=%b cause=%0d",
                     tag, addr_err, stack_err, cause, ae, se, c);
        end
    endtask

    // Monitor: one expectation per clock edge, sampled just after the edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exq.size() > 0) begin
                e = exq.pop_front();
                compare(e.tag, e.ae, e.se, e.c);
            end
        end
    end

    task automatic dacc(bit prog, bit word, logic [23:0] a);
        dacc_valid = 1; dacc_prog = prog; dacc_word = word; dacc_addr = a;
    endtask

    task automatic spw(logic [15:0] v);
        sp_wr = 1; sp_wdata = v;
    endtask

    // Driver: stimulus is already applied; queue its result, advance a cycle, idle strobes.
    task automatic cyc(string tag, bit ae, bit se, bit [2:0] c);
        exq.push_back('{tag: tag, ae: ae, se: se, c: c});
        @(negedge clk);
        dacc_valid = 0; fetch_valid = 0; br_valid = 0;
        sp_wr = 0; lim_wr = 0; cause_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R11 in reset", 0, 0, 0);
        rst_n = 1;

        cyc("R11 idle after reset", 0, 0, 0);
        dacc(0, 0, 24'h000801);              cyc("R1 odd byte ok", 0, 0, 0);
        dacc(0, 1, 24'h000803);              cyc("R1 odd word", 1, 0, 1);
        cause_clr = 1;                       cyc("R10 clear alone", 0, 0, 0);
        dacc(0, 1, 24'h000900);              cyc("R2 in range", 0, 0, 0);
        dacc(0, 1, 24'h001000);              cyc("R2 above data", 1, 0, 2);
        dacc(0, 0, 24'h000400);              cyc("R10 sticky R2 below", 1, 0, 2);
        cause_clr = 1; dacc(1, 1, 24'h008000); cyc("R3 prog unimpl with clear", 1, 0, 3);
        cause_clr = 1; dacc(1, 1, 24'h007FFE); cyc("R3 prog top ok", 0, 0, 0);
        fetch_valid = 1; fetch_addr = 24'h0000FE; cyc("R4 vector top", 1, 0, 4);
        cause_clr = 1; fetch_valid = 1; fetch_addr = 24'h000100; cyc("R4 past vectors", 0, 0, 0);
        fetch_valid = 1; fetch_addr = 24'h008000; cyc("R5 fetch unimpl", 1, 0, 5);
        cause_clr = 1; br_valid = 1; br_target = 24'h009000; cyc("R5 branch unimpl", 1, 0, 5);
        cause_clr = 1; br_valid = 1; br_target = 24'h000100; cyc("R5 branch ok", 0, 0, 0);
        spw(16'hFFFE);                       cyc("R6 reset ceiling", 0, 0, 0);
        lim_wr = 1; lim_wdata = 16'h0A00; spw(16'h0B00); cyc("R6 old ceiling used", 0, 0, 0);
        spw(16'h0B00);                       cyc("R6 overflow", 0, 1, 6);
        cause_clr = 1; spw(16'h0A00);        cyc("R6 equal ok", 0, 0, 0);
        spw(16'h07FE);                       cyc("R7 underflow", 0, 1, 7);
        cause_clr = 1; spw(16'h0800);        cyc("R7 floor ok", 0, 0, 0);
        dacc(0, 1, 24'h000803); spw(16'h0C00); cyc("R9 both, ovf wins", 1, 1, 6);
        cause_clr = 1; dacc(0, 1, 24'h000803); spw(16'h0700);
        fetch_valid = 1; fetch_addr = 24'h000010; cyc("R9 unf wins", 1, 1, 7);
        cause_clr = 1; dacc(0, 1, 24'h001001); cyc("R9 misalign over range", 1, 0, 1);
        cause_clr = 1; dacc_addr = 24'h000003; dacc_word = 1;
        fetch_addr = 24'h000000; br_target = 24'hFFFFFF; sp_wdata = 16'h0000;
        cyc("R8 strobes low", 0, 0, 0);
        cyc("R8 pulse drops", 0, 0, 0);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule